// File: doc/BRIEF.md
# Short Relative Branch Resolver

This block decides whether a two-byte short relative branch is taken, and gives the address that execution continues from. The opcode range is 0x20 to 0x2F, and the branch may carry an optional 0x90 prefix byte. The low nibble of the opcode selects one of sixteen conditions. The conditions read the condition-code flags (V, I, H, N, Z, C) and, for some prefixed forms, the level of the external interrupt line.

In the execute stage the caller presents these on a single cycle, qualified by `valid_i`:

- the address of the first instruction byte (the prefix byte when there is one);
- the condition nibble;
- the prefix flag;
- the signed 8-bit displacement;
- the flags and the interrupt line level.

One clock later the block returns:

- the taken decision;
- the next program counter. This is the sequential address, or the sequential address plus the sign-extended displacement. It wraps in 16 bits.

The result registers hold their values while `valid_i` is low.

The even and odd members of each condition pair are exact complements. The prefix changes the meaning of only six of the sixteen codes. It also lengthens the instruction by one byte.

Top module: `brc_resolve`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `taken_o` and `next_pc_o` are all zero.
- R2: `valid_o` equals `valid_i` one clock earlier. When `valid_i` was low, `taken_o` and `next_pc_o` keep their previous values.
- R3: Condition code 0 is always taken and code 1 is never taken, whatever the flags and the prefix.
- R4: Code 2 is taken when C=0 and Z=0. Code 3 is taken when C=1 or Z=1.
- R5: Codes 4 and 5 are taken when C=0 and C=1. Codes 6 and 7 are taken when Z=0 and Z=1.
- R6: Without the prefix, codes 8 and 9 are taken when V=0 and V=1, and codes 0xA and 0xB are taken when N=0 and N=1.
- R7: Without the prefix:
  - code 0xC is taken when Z=0 and N equals V;
  - code 0xD is its complement;
  - code 0xE is taken when N equals V;
  - code 0xF is taken when N differs from V.
- R8: With the prefix:
  - codes 8 and 9 test H=0 and H=1;
  - codes 0xC and 0xD test I=0 and I=1;
  - codes 0xE and 0xF are taken when `irq_lvl_i` is low and high.
- R9: Codes 0 to 7, 0xA and 0xB give the same decision with and without the prefix. `irq_lvl_i` affects only prefixed codes 0xE and 0xF.
- R10: `next_pc_o` is `pc_i` plus 2 (plus 3 when prefixed) when the branch is not taken. When the branch is taken, the sign-extended `ofs_i` is added as well. All arithmetic is modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Branch request present this cycle |
| pc_i | input | 16 | Address of the first byte of the branch (prefix byte if present) |
| cond_i | input | 4 | Condition nibble from the opcode |
| pfx_i | input | 1 | 0x90 prefix precedes the opcode |
| ofs_i | input | 8 | Signed displacement |
| ccr_i | input | 6 | Flags packed as {V, I, H, N, Z, C}, C in bit 0 |
| irq_lvl_i | input | 1 | Level of the external interrupt line |
| valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Address execution continues from |

## Verification
The condition decision and the target selection resolve in the same cycle, and the prefix acts on both at once. It changes the tested flag for six codes, and it also moves the sequential address by one byte.

The bench sweeps every condition, both prefix states, all 64 flag patterns and both interrupt levels back to back. It uses a nonzero displacement that changes from vector to vector, so a taken branch and a fall-through never produce the same address. Each result is judged on both the decision and the exact next address. The sweep includes a wrap past 0xFFFF and the extreme displacements 0x7F and 0x80.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned CCR_W = 6;

  typedef struct packed {
    logic v;
    logic i;
    logic h;
    logic n;
    logic z;
    logic c;
  } ccr_t;

  // predicate pair index = cond[3:1]
  typedef enum logic [2:0] {
    PR_ALWAYS = 3'd0,
    PR_UGT    = 3'd1,
    PR_NC     = 3'd2,
    PR_NZ     = 3'd3,
    PR_ALT_A  = 3'd4,
    PR_PL     = 3'd5,
    PR_ALT_B  = 3'd6,
    PR_ALT_C  = 3'd7
  } pair_e;
endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
(
  input  logic [3:0] cond_i,
  input  logic       pfx_i,
  input  ccr_t       ccr_i,
  input  logic       irq_lvl_i,
  output logic       take_o
);
  localparam int unsigned NPAIR = 8;

  logic [NPAIR-1:0] pred;
  logic             n_eq_v;

  assign n_eq_v = ~(ccr_i.n ^ ccr_i.v);

  always_comb begin
    pred           = '0;
    pred[PR_ALWAYS] = 1'b1;
    pred[PR_UGT]    = ~ccr_i.c & ~ccr_i.z;
    pred[PR_NC]     = ~ccr_i.c;
    pred[PR_NZ]     = ~ccr_i.z;
    pred[PR_ALT_A]  = pfx_i ? ~ccr_i.h : ~ccr_i.v;
    pred[PR_PL]     = ~ccr_i.n;
    pred[PR_ALT_B]  = pfx_i ? ~ccr_i.i : (~ccr_i.z & n_eq_v);
    pred[PR_ALT_C]  = pfx_i ? ~irq_lvl_i : n_eq_v;
  end

  // odd codes are the complement of their even partner
  assign take_o = pred[cond_i[3:1]] ^ cond_i[0];
endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int unsigned PC_W    = 16,
  parameter int unsigned OFS_W   = 8,
  parameter int unsigned OP_LEN  = 2,
  parameter int unsigned PFX_LEN = 1
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic             pfx_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             take_i,
  output logic [PC_W-1:0]  next_pc_o
);
  localparam logic [PC_W-1:0] STEP_S = PC_W'(OP_LEN);
  localparam logic [PC_W-1:0] STEP_P = PC_W'(OP_LEN + PFX_LEN);

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] ofs_sx;

  assign seq_pc    = pc_i + (pfx_i ? STEP_P : STEP_S);
  assign ofs_sx    = {{(PC_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
  assign next_pc_o = take_i ? (seq_pc + ofs_sx) : seq_pc;
endmodule

// File: rtl/brc_resolve.sv
module brc_resolve
  import brc_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [3:0]       cond_i,
  input  logic             pfx_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [CCR_W-1:0] ccr_i,
  input  logic             irq_lvl_i,
  output logic             valid_o,
  output logic             taken_o,
  output logic [PC_W-1:0]  next_pc_o
);
  logic            take_d;
  logic [PC_W-1:0] npc_d;

  brc_cond_eval u_cond (
    .cond_i    (cond_i),
    .pfx_i     (pfx_i),
    .ccr_i     (ccr_t'(ccr_i)),
    .irq_lvl_i (irq_lvl_i),
    .take_o    (take_d)
  );

  brc_target #(
    .PC_W  (PC_W),
    .OFS_W (OFS_W)
  ) u_tgt (
    .pc_i      (pc_i),
    .pfx_i     (pfx_i),
    .ofs_i     (ofs_i),
    .take_i    (take_d),
    .next_pc_o (npc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      next_pc_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o   <= take_d;
        next_pc_o <= npc_d;
      end
    end
  end
endmodule

// File: rtl/brc_resolve_chk.sv
module brc_resolve_chk #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFS_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [PC_W-1:0]  pc_i,
  input logic [3:0]       cond_i,
  input logic             pfx_i,
  input logic [OFS_W-1:0] ofs_i,
  input logic [5:0]       ccr_i,
  input logic             irq_lvl_i,
  input logic             valid_o,
  input logic             taken_o,
  input logic [PC_W-1:0]  next_pc_o
);
  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(taken_o) && $stable(next_pc_o)));
  // R3
  always_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == 4'h0) |=> taken_o);
  // R3
  never_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == 4'h1) |=> !taken_o);
  // R4
  ugt_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == 4'h2 && ccr_i[1:0] == 2'b00) |=> taken_o);
  // R8
  irq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pfx_i && cond_i == 4'hE) |=> (taken_o == !$past(irq_lvl_i)));
  // R10
  fall_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == 4'h1) |=>
      (next_pc_o == PC_W'($past(pc_i) + ($past(pfx_i) ? 3 : 2))));
endmodule

bind brc_resolve brc_resolve_chk #(.PC_W(PC_W), .OFS_W(OFS_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .pc_i      (pc_i),
  .cond_i    (cond_i),
  .pfx_i     (pfx_i),
  .ofs_i     (ofs_i),
  .ccr_i     (ccr_i),
  .irq_lvl_i (irq_lvl_i),
  .valid_o   (valid_o),
  .taken_o   (taken_o),
  .next_pc_o (next_pc_o)
);

// File: tb/brc_resolve_tb_top.sv
`timescale 1ns/1ps
module brc_resolve_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [3:0]  cond_i = '0;
  logic        pfx_i = 1'b0;
  logic [7:0]  ofs_i = '0;
  logic [5:0]  ccr_i = '0;
  logic        irq_lvl_i = 1'b0;
  logic        valid_o;
  logic        taken_o;
  logic [15:0] next_pc_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [16:0] exp_q[$];
  string       tag_q[$];
  logic        last_tk;
  logic [15:0] last_pc;

  always #10 clk_i = ~clk_i;

  brc_resolve dut_i (.*);

  // {V,I,H,N,Z,C} in ccr bits 5..0
  function automatic logic ref_take(input logic [3:0] c, input logic p,
                                    input logic [5:0] f, input logic irq);
    logic v, i, h, n, z, cy;
    {v, i, h, n, z, cy} = f;
    case (c)
      4'h0: return 1'b1;
      4'h1: return 1'b0;
      4'h2: return !cy && !z;
      4'h3: return cy || z;
      4'h4: return !cy;
      4'h5: return cy;
      4'h6: return !z;
      4'h7: return z;
      4'h8: return p ? !h : !v;
      4'h9: return p ? h : v;
      4'hA: return !n;
      4'hB: return n;
      4'hC: return p ? !i : (!z && (n == v));
      4'hD: return p ? i : (z || (n != v));
      4'hE: return p ? !irq : (n == v);
      default: return p ? irq : (n != v);
    endcase
  endfunction

  function automatic string ref_tag(input logic [3:0] c, input logic p);
    if (c < 4'h2) return "R3";
    if (c < 4'h4) return "R4";
    if (c < 4'h8) return p ? "R9" : "R5";
    if (c == 4'hA || c == 4'hB) return p ? "R9" : "R6";
    if (p) return "R8";
    return (c < 4'hA) ? "R6" : "R7";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] pc, input logic [3:0] c, input logic p,
                       input logic [7:0] o, input logic [5:0] f, input logic irq);
    logic        tk;
    logic [15:0] seq;
    @(negedge clk_i);
    valid_i = 1'b1; pc_i = pc; cond_i = c; pfx_i = p; ofs_i = o; ccr_i = f;
    irq_lvl_i = irq;
    tk  = ref_take(c, p, f, irq);
    seq = pc + (p ? 16'd3 : 16'd2);
    exp_q.push_back({tk, tk ? 16'(seq + {{8{o[7]}}, o}) : seq});
    tag_q.push_back(ref_tag(c, p));
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", 32'(valid_o), 32'd0);
      end else begin
        logic [16:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(taken_o == e[16], t, 32'(taken_o), 32'(e[16]));
        check(next_pc_o == e[15:0], "R10", 32'(next_pc_o), 32'(e[15:0]));
        last_tk = taken_o;
        last_pc = next_pc_o;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    check(valid_o == 1'b0 && taken_o == 1'b0 && next_pc_o == 16'h0, "R1",
          {15'd0, valid_o, taken_o, next_pc_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2: idle after reset
    check(valid_o == 1'b0, "R2", 32'(valid_o), 32'd0);
    for (int k = 0; k < 4096; k++) begin
      logic [15:0] pc;
      logic [7:0]  o;
      pc = 16'h4000 + 16'(k * 37);
      o  = 8'(k * 13 + 5);
      if (o == 8'h00) o = 8'h01;
      drive(pc, k[3:0], k[4], o, k[10:5], k[11]);
    end
    // R10 boundaries: wrap past 0xFFFF and extreme displacements
    drive(16'hFFFE, 4'h0, 1'b0, 8'h7F, 6'h00, 1'b0);
    drive(16'hFFFF, 4'h0, 1'b1, 8'h01, 6'h00, 1'b0);
    drive(16'h0001, 4'h0, 1'b0, 8'h80, 6'h00, 1'b0);
    drive(16'h0000, 4'h0, 1'b1, 8'h80, 6'h3F, 1'b1);
    drive(16'hFFFD, 4'h1, 1'b1, 8'h80, 6'h00, 1'b0);
    // R2: idle stimulus must not disturb held result
    @(negedge clk_i);
    valid_i = 1'b0; pc_i = 16'h1234; cond_i = 4'h0; ofs_i = 8'h40; ccr_i = 6'h15;
    pfx_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check(valid_o == 1'b0, "R2", 32'(valid_o), 32'd0);
    check(taken_o == last_tk && next_pc_o == last_pc, "R2",
          {15'd0, taken_o, next_pc_o}, {15'd0, last_tk, last_pc});
    check(exp_q.size() == 0, "R2", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule